// File: doc/BRIEF.md
# Flash Command Decoder State Machine

This block is a clock-synchronous model of the command front end of a byte-wide flash memory that erases in 256-byte sectors and programs single bytes. A host issues bus writes (`wr_stb` with an address and a command or data byte) and bus reads (`rd_stb` with an address). Writes are decoded into setup-then-execute sequences for sector erase and byte program, a sequence abort, and an identification mode. A completed sequence sends one request pulse, with its address and data, to a storage array outside the block.

After an execute cycle the block stays busy for a parameterised number of clock cycles. While busy, every read returns a status byte instead of array data. Its top bit is the complement of the byte being written (0xFF for an erase), and bit 6 flips on each read. Modifying operations are blocked until a seven-read unlock address sequence has been seen. The block comes out of reset locked and in read mode. A matching seven-read sequence with a different final address locks it again.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read mode and locked; `rd_data` is 0x00, no array request is active, and a read returns `arr_rdata`.
- R2: While locked, the setup commands 0x20 (erase) and 0x10 (program) are refused: the block stays in read mode, the following write issues no array request, and reads still return array data.
- R3: Seven consecutive reads whose address bits 15:0 are 0x1823, 0x1820, 0x1822, 0x0418, 0x041B, 0x0419, 0x041A clear the lock; the same first six followed by 0x040A set it. Address bits 18:16 are ignored. A read that breaks the order restarts matching, counting itself as the first step if it is 0x1823.
- R4: When unlocked, 0x10 followed by any write other than 0xFF raises `arr_wr_req` for exactly one cycle, in the cycle after that second write, with `arr_addr` and `arr_wdata` equal to its address and data.
- R5: When unlocked, 0x20 followed by 0xD0 raises `arr_erase_req` for one cycle after the 0xD0 write, with `arr_addr` equal to the write address with bits 7:0 forced to zero.
- R6: A write other than 0xD0 after 0x20 discards the erase sequence and returns the block to read mode, so a later 0xD0 alone issues nothing.
- R7: 0xFF written after either setup command aborts it with no request and does not change the lock state.
- R8: 0x90 enters identification mode, in which reads of address 0 return 0xBF, reads of address 1 return 0x04, and other addresses return array data. Unknown command bytes keep the mode. 0xFF, 0x10 and 0x20 leave it.
- R9: While busy, a read returns {~P[7], T, P[5:0]}, where P is the programmed byte (0xFF for erase) and T is 0 on the first read after the start and inverts on each later read.
- R10: Busy lasts PROG_CYCLES clock cycles after the program execute write and ERASE_CYCLES after the erase execute write; the next read returns array data.
- R11: While busy, writes are ignored except 0xFF, which ends the busy phase at once.
- R12: `rd_data` is registered: it takes its new value in the cycle after a read strobe and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Bus write strobe, one cycle per write |
| rd_stb | input | 1 | Bus read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Bus address for reads and writes |
| bus_wdata | input | 8 | Command or data byte of a write |
| arr_rdata | input | 8 | Array byte at `bus_addr`, supplied by the array |
| rd_data | output | 8 | Registered read result |
| arr_wr_req | output | 1 | One-cycle byte program request |
| arr_erase_req | output | 1 | One-cycle sector erase request |
| arr_addr | output | ADDR_W | Program address or sector base address |
| arr_wdata | output | 8 | Byte to program |

## Verification
A table of reads and writes exercises plain read mode and identification mode. It uses a full-address read (0x10000) to show that only addresses 0 and 1 give the ID codes, and an unknown byte that must not leave the mode. Directed sequences then try program and erase both locked and unlocked, a broken unlock sequence that must leave the block locked, a wrong execute byte, and aborts from each setup and from busy. Counted status reads tell a busy phase that is one cycle too short or too long from a correct one. Distinct data patterns (0x5A, 0xFF from erase) separate the inverted bit 7 and the toggling bit 6 from the plain low bits.

// File: rtl/flash_cmd_pkg.sv
// Package: shared state type, command codes and the lock sequence
// addresses for the flash command decoder.
package flash_cmd_pkg;
    localparam int BYTE_W     = 8;
    localparam int SEQ_ADDR_W = 16;
    localparam int SEQ_LEN    = 7;

    typedef enum logic [2:0] {
        S_READ, S_ID, S_ERS_SET, S_PGM_SET, S_ERS_RUN, S_PGM_RUN
    } cmd_state_e;

    localparam logic [BYTE_W-1:0] CMD_ERS_SETUP = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_ERS_GO    = 8'hD0;
    localparam logic [BYTE_W-1:0] CMD_PGM_SETUP = 8'h10;
    localparam logic [BYTE_W-1:0] CMD_ABORT     = 8'hFF;
    localparam logic [BYTE_W-1:0] CMD_IDENT     = 8'h90;
    localparam logic [BYTE_W-1:0] IDENT_MAKER   = 8'hBF;
    localparam logic [BYTE_W-1:0] IDENT_PART    = 8'h04;
    localparam logic [BYTE_W-1:0] ERASED_BYTE   = 8'hFF;

    localparam logic [SEQ_ADDR_W-1:0] SEQ_OPEN_LAST  = 16'h041A;
    localparam logic [SEQ_ADDR_W-1:0] SEQ_CLOSE_LAST = 16'h040A;

    // Address expected at each shared step of the lock sequences.
    function automatic logic [SEQ_ADDR_W-1:0] seq_step_addr(input int idx);
        case (idx)
            0:       return 16'h1823;
            1:       return 16'h1820;
            2:       return 16'h1822;
            3:       return 16'h0418;
            4:       return 16'h041B;
            5:       return 16'h0419;
            default: return SEQ_OPEN_LAST;
        endcase
    endfunction
endpackage

// File: rtl/flash_lock_seq.sv
// Module: flash_lock_seq
// Watches read strobes for the seven-address lock/unlock sequence and
// keeps the write lock. Assumes one read per strobe cycle; the lock is
// set by reset.
module flash_lock_seq
    import flash_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_stb,
    input  logic [SEQ_ADDR_W-1:0] rd_addr,
    output logic                  locked
);
    localparam int STEP_W = $clog2(SEQ_LEN);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    logic [STEP_W-1:0] step_q;
    logic              lock_q;
    logic              is_first;
    logic              is_next;

    // Compare the read address with the first and the expected step.
    always_comb begin
        is_first = (rd_addr == seq_step_addr(0));
        is_next  = (rd_addr == seq_step_addr(int'(step_q)));
    end

    // Advance or restart the sequence, update the lock on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            lock_q <= 1'b1;
        end else if (rd_stb) begin
            if (step_q == LAST_STEP) begin
                if (rd_addr == SEQ_OPEN_LAST) begin
                    lock_q <= 1'b0;
                end else if (rd_addr == SEQ_CLOSE_LAST) begin
                    lock_q <= 1'b1;
                end
                step_q <= is_first ? STEP_W'(1) : '0;
            end else if (is_next) begin
                step_q <= step_q + 1'b1;
            end else begin
                step_q <= is_first ? STEP_W'(1) : '0;
            end
        end
    end

    assign locked = lock_q;
endmodule

// File: rtl/flash_busy_timer.sv
// Module: flash_busy_timer
// Down-counter for the self-timed busy phase. A start loads the length
// minus one; expired is high while the count is zero. Assumes
// ERASE_CYCLES >= PROG_CYCLES >= 1.
module flash_busy_timer #(
    parameter int ERASE_CYCLES = 200000,
    parameter int PROG_CYCLES  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ers,
    input  logic start_pgm,
    input  logic abort,
    output logic expired
);
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
    localparam logic [CNT_W-1:0] ERS_LOAD = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PGM_LOAD = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, clear on abort, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_ers) begin
            cnt_q <= ERS_LOAD;
        end else if (start_pgm) begin
            cnt_q <= PGM_LOAD;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_rd_path.sv
// Module: flash_rd_path
// Selects and registers read data: status while busy, ID codes in
// identification mode, array data otherwise. Keeps the toggle bit.
// Assumes reads and busy starts do not fall in the same cycle.
module flash_rd_path
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] arr_rdata,
    input  cmd_state_e        st,
    input  logic [BYTE_W-1:0] poll_byte,
    input  logic              tog_clr,
    output logic [BYTE_W-1:0] rd_data
);
    logic              busy;
    logic              tog_q;
    logic [BYTE_W-1:0] rd_next;
    logic [BYTE_W-1:0] rd_q;

    // Choose the byte a read returns in the current state.
    always_comb begin
        busy = (st == S_ERS_RUN) || (st == S_PGM_RUN);
        if (busy) begin
            rd_next = {~poll_byte[BYTE_W-1], tog_q, poll_byte[BYTE_W-3:0]};
        end else if (st == S_ID && rd_addr == ADDR_W'(0)) begin
            rd_next = IDENT_MAKER;
        end else if (st == S_ID && rd_addr == ADDR_W'(1)) begin
            rd_next = IDENT_PART;
        end else begin
            rd_next = arr_rdata;
        end
    end

    // Register the read result and flip the toggle bit on busy reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            tog_q <= 1'b0;
        end else begin
            if (rd_stb) begin
                rd_q <= rd_next;
            end
            if (tog_clr) begin
                tog_q <= 1'b0;
            end else if (rd_stb && busy) begin
                tog_q <= ~tog_q;
            end
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Module: flash_cmd_ctrl (top)
// Command decoder for a byte-program, sector-erase flash. Decodes bus
// writes into setup/execute sequences, issues one-cycle array requests,
// runs the busy phase and routes reads. Assumes single-cycle strobes
// and never a read and a write in the same cycle.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int SECT_W       = 8,
    parameter int ERASE_CYCLES = 200000,
    parameter int PROG_CYCLES  = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        rd_data,
    output logic              arr_wr_req,
    output logic              arr_erase_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);
    cmd_state_e        st_q, st_d;
    logic              locked;
    logic              timer_done;
    logic              start_ers, start_pgm, abort_run;
    logic              wr_req_q, ers_req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] wdata_q, poll_q;

    flash_lock_seq u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (bus_addr[SEQ_ADDR_W-1:0]),
        .locked  (locked)
    );

    flash_busy_timer #(
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROG_CYCLES  (PROG_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ers (start_ers),
        .start_pgm (start_pgm),
        .abort     (abort_run),
        .expired   (timer_done)
    );

    flash_rd_path #(
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .rd_addr   (bus_addr),
        .arr_rdata (arr_rdata),
        .st        (st_q),
        .poll_byte (poll_q),
        .tog_clr   (start_ers | start_pgm),
        .rd_data   (rd_data)
    );

    // Next-state and start/abort decode of the command sequencer.
    always_comb begin
        st_d      = st_q;
        start_ers = 1'b0;
        start_pgm = 1'b0;
        abort_run = 1'b0;
        case (st_q)
            S_READ, S_ID: begin
                if (wr_stb) begin
                    case (bus_wdata)
                        CMD_ERS_SETUP: st_d = locked ? S_READ : S_ERS_SET;
                        CMD_PGM_SETUP: st_d = locked ? S_READ : S_PGM_SET;
                        CMD_IDENT:     st_d = S_ID;
                        CMD_ABORT:     st_d = S_READ;
                        default:       st_d = st_q;
                    endcase
                end
            end
            S_ERS_SET: begin
                if (wr_stb) begin
                    if (bus_wdata == CMD_ERS_GO) begin
                        start_ers = 1'b1;
                        st_d      = S_ERS_RUN;
                    end else begin
                        st_d = S_READ;
                    end
                end
            end
            S_PGM_SET: begin
                if (wr_stb) begin
                    if (bus_wdata == CMD_ABORT) begin
                        st_d = S_READ;
                    end else begin
                        start_pgm = 1'b1;
                        st_d      = S_PGM_RUN;
                    end
                end
            end
            S_ERS_RUN, S_PGM_RUN: begin
                if (wr_stb && bus_wdata == CMD_ABORT) begin
                    abort_run = 1'b1;
                    st_d      = S_READ;
                end else if (timer_done) begin
                    st_d = S_READ;
                end
            end
            default: st_d = S_READ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_READ;
        end else begin
            st_q <= st_d;
        end
    end

    // Array request pulses, their address and data, and the polled byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req_q  <= 1'b0;
            ers_req_q <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            poll_q    <= '0;
        end else begin
            wr_req_q  <= start_pgm;
            ers_req_q <= start_ers;
            if (start_pgm) begin
                addr_q  <= bus_addr;
                wdata_q <= bus_wdata;
                poll_q  <= bus_wdata;
            end else if (start_ers) begin
                addr_q <= {bus_addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
                poll_q <= ERASED_BYTE;
            end
        end
    end

    assign arr_wr_req    = wr_req_q;
    assign arr_erase_req = ers_req_q;
    assign arr_addr      = addr_q;
    assign arr_wdata     = wdata_q;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Module: flash_cmd_ctrl_chk
// Protocol checks for flash_cmd_ctrl, attached by bind below.
module flash_cmd_ctrl_chk
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        rd_data,
    input logic              arr_wr_req,
    input logic              arr_erase_req,
    input logic [ADDR_W-1:0] arr_addr,
    input cmd_state_e        st_q
);
    logic busy;
    assign busy = (st_q == S_ERS_RUN) || (st_q == S_PGM_RUN);

    assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_wr_req, arr_erase_req}));

    assert_pgm_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_req |=> !arr_wr_req);

    assert_pgm_after_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_req |-> $past(st_q) == S_PGM_SET);

    assert_ers_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase_req |-> arr_addr[SECT_W-1:0] == '0);

    assert_ers_needs_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase_req |-> ($past(wr_stb) && $past(bus_wdata) == CMD_ERS_GO));

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && bus_wdata != CMD_ABORT) |=>
            (st_q != S_ERS_SET && st_q != S_PGM_SET && st_q != S_ID));

    assert_busy_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && bus_wdata == CMD_ABORT) |=> st_q == S_READ);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .rd_stb        (rd_stb),
    .bus_wdata     (bus_wdata),
    .rd_data       (rd_data),
    .arr_wr_req    (arr_wr_req),
    .arr_erase_req (arr_erase_req),
    .arr_addr      (arr_addr),
    .st_q          (st_q)
);

// File: tb/test_flash_cmd_ctrl.sv
// Bench for flash_cmd_ctrl: table walk for read/ID mode, then directed
// sequences for lock, program, erase, abort and busy timing.
module test_flash_cmd_ctrl;
    localparam int ADDR_W = 19;
    localparam int ERS_N  = 40;
    localparam int PGM_N  = 8;
    localparam int NVEC   = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_stb = 1'b0;
    logic              rd_stb = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        arr_rdata;
    logic [7:0]        rd_data;
    logic              arr_wr_req, arr_erase_req;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_wdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    // Array model: data depends only on the low address byte.
    assign arr_rdata = bus_addr[7:0] ^ 8'h3C;

    flash_cmd_ctrl #(
        .ADDR_W       (ADDR_W),
        .ERASE_CYCLES (ERS_N),
        .PROG_CYCLES  (PGM_N)
    ) i_flash_cmd_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stb        (wr_stb),
        .rd_stb        (rd_stb),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .arr_rdata     (arr_rdata),
        .rd_data       (rd_data),
        .arr_wr_req    (arr_wr_req),
        .arr_erase_req (arr_erase_req),
        .arr_addr      (arr_addr),
        .arr_wdata     (arr_wdata)
    );

    // Vector: {is_read, addr, write byte, expected read byte}
    typedef logic [1+ADDR_W+8+8-1:0] vec_t;
    localparam vec_t VECS [NVEC] = '{
        {1'b1, 19'h00000, 8'h00, 8'h3C},
        {1'b1, 19'h00001, 8'h00, 8'h3D},
        {1'b0, 19'h00000, 8'h90, 8'h00},
        {1'b1, 19'h00000, 8'h00, 8'hBF},
        {1'b1, 19'h00001, 8'h00, 8'h04},
        {1'b1, 19'h00002, 8'h00, 8'h3E},
        {1'b1, 19'h10000, 8'h00, 8'h3C},
        {1'b0, 19'h00000, 8'h55, 8'h00},
        {1'b1, 19'h00000, 8'h00, 8'hBF},
        {1'b0, 19'h00000, 8'hFF, 8'h00},
        {1'b1, 19'h00000, 8'h00, 8'h3C}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Each operation starts and ends at a falling edge and spans one rising edge.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a);
        bus_addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic seq_reads(input logic [15:0] last);
        do_read(19'h71823); do_read(19'h01820); do_read(19'h01822);
        do_read(19'h00418); do_read(19'h0041B); do_read(19'h00419);
        do_read({3'b000, last});
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rd_data after reset", rd_data, 8'h00);
        chk("R1 no request after reset", {arr_wr_req, arr_erase_req}, 2'b00);

        // R8 / R1: table walk of read and identification mode
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            if (v[35]) begin
                do_read(v[34:16]);
                chk($sformatf("R8 vector %0d", i), rd_data, v[7:0]);
            end else begin
                do_write(v[34:16], v[15:8]);
            end
        end

        // R2: program and erase refused while locked
        do_write(19'h00000, 8'h10);
        do_write(19'h00123, 8'h77);
        chk("R2 locked program", arr_wr_req, 1'b0);
        do_read(19'h00123);
        chk("R2 locked read is array", rd_data, 8'h1F);
        do_write(19'h00000, 8'h20);
        do_write(19'h00300, 8'hD0);
        chk("R2 locked erase", arr_erase_req, 1'b0);

        // R3: broken unlock sequence keeps the lock
        do_read(19'h01823); do_read(19'h01820); do_read(19'h01822);
        do_read(19'h00418); do_read(19'h09999); do_read(19'h0041B);
        do_read(19'h00419); do_read(19'h0041A);
        do_write(19'h00000, 8'h10);
        do_write(19'h00010, 8'h11);
        chk("R3 broken sequence stays locked", arr_wr_req, 1'b0);

        // R3 / R4: unlock (bit 16 set on first address) then program
        seq_reads(16'h041A);
        do_write(19'h00000, 8'h10);
        do_write(19'h01234, 8'h5A);
        chk("R4 wr_req", arr_wr_req, 1'b1);
        chk("R4 addr", arr_addr, 19'h01234);
        chk("R4 data", arr_wdata, 8'h5A);
        // R9 / R10: PGM_N status reads, then array data
        for (int k = 0; k < PGM_N; k++) begin
            do_read(19'h01234);
            if (k == 0) chk("R4 single-cycle pulse", arr_wr_req, 1'b0);
            chk($sformatf("R9 status read %0d", k), rd_data,
                (k % 2 == 0) ? 8'h9A : 8'hDA);
        end
        do_read(19'h01234);
        chk("R10 program done, array data", rd_data, 8'h08);

        // R5: erase with sector alignment
        do_write(19'h00000, 8'h20);
        do_write(19'h4A7F3, 8'hD0);
        chk("R5 erase_req", arr_erase_req, 1'b1);
        chk("R5 sector addr", arr_addr, 19'h4A700);
        do_read(19'h4A7F3);
        chk("R9 erase status first", rd_data, 8'h3F);
        // R11: a program setup during busy is ignored
        do_write(19'h00000, 8'h10);
        chk("R11 busy write no request", arr_wr_req, 1'b0);
        repeat (ERS_N - 3) @(negedge clk);
        do_read(19'h4A7F3);
        chk("R10 erase last busy cycle status", rd_data, 8'h7F);
        do_read(19'h4A7F3);
        chk("R10 erase done, array data", rd_data, 8'hCF);
        do_write(19'h00044, 8'h77);
        chk("R11 ignored setup left no sequence", arr_wr_req, 1'b0);

        // R11: abort during busy
        do_write(19'h00000, 8'h10);
        do_write(19'h00050, 8'h33);
        do_read(19'h00050);
        chk("R9 status before abort", rd_data, 8'h B3);
        do_write(19'h00000, 8'hFF);
        do_read(19'h00050);
        chk("R11 abort ends busy", rd_data, 8'h6C);

        // R6: wrong execute byte discards erase
        do_write(19'h00000, 8'h20);
        do_write(19'h00100, 8'h77);
        chk("R6 wrong execute", arr_erase_req, 1'b0);
        do_write(19'h00100, 8'hD0);
        chk("R6 lone execute", arr_erase_req, 1'b0);

        // R7: abort after setup keeps unlock state
        do_write(19'h00000, 8'h10);
        do_write(19'h00000, 8'hFF);
        chk("R7 abort no request", arr_wr_req, 1'b0);
        do_write(19'h00000, 8'h10);
        do_write(19'h00200, 8'hA5);
        chk("R7 still unlocked", arr_wr_req, 1'b1);
        repeat (PGM_N + 2) @(negedge clk);

        // R12: rd_data holds without a read strobe
        do_read(19'h00007);
        bus_addr = 19'h000F0;
        repeat (3) @(negedge clk);
        chk("R12 rd_data held", rd_data, 8'h3B);

        // R3: lock sequence sets protection again
        seq_reads(16'h040A);
        do_write(19'h00000, 8'h10);
        do_write(19'h00020, 8'h22);
        chk("R3 relocked", arr_wr_req, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule